// File: doc/BRIEF.md
# Cache Allocate Hint Generator

This block sits where commands from I/O sources enter the coherent bus and attaches to each one a single flag that asks the shared cache to allocate the line when the access misses. Each command is evaluated on its own. The block picks the rule to apply from the source type: an on-chip DMA engine, the HyperTransport link, the PCI bridge, or any other requester.

Software programs a small set of configuration registers through a write port. These hold the following settings:
- per-engine enables for descriptor traffic and for packet-header traffic;
- an address base and mask that define a HyperTransport allocate window;
- a control bit that enables that window;
- one allocate attribute per PCI translation window.

The command leaves the block one cycle later with its flag attached. Clearing the DMA enables at run time stops allocation by I/O traffic when the system is overloaded.

Top module: `alloc_hint_gen`

## Requirements
- R1: Each command appears on the outputs exactly one cycle after it is presented. `out_valid`, `out_src` and `out_addr` equal the previous cycle's `cmd_valid`, `cmd_src` and `cmd_addr`.
- R2: For source code 0 (DMA) with kind code 1 (descriptor), the flag equals bit `cmd_dma_id` of the descriptor-enable register (select 3).
- R3: For source code 0 with kind code 2 (header), the flag equals bit `cmd_dma_id` of the header-enable register (select 4). Kind codes 0 (payload) and 3 (reserved) never set the flag.
- R4: For source code 1 (HyperTransport), a set `cmd_isoc` sets the flag whatever the address and window settings are.
- R5: For source code 1, when control bit 0 (select 2) is 1, the flag is set if `(cmd_addr & mask) == (base & mask)`. The base is at select 0 and the mask at select 1. The HyperTransport flag is the OR of this window rule and the R4 rule.
- R6: When control bit 0 is 0, the address window has no effect on the flag.
- R7: For source code 2 (PCI), the flag equals `cmd_pci_hit` AND bit `cmd_pci_win` of the attribute register (select 5).
- R8: Source code 3 never sets the flag. `out_alloc` is 0 whenever `out_valid` is 0.
- R9: A configuration write (`cfg_we` with `cfg_sel` and `cfg_wdata`) affects commands presented in later cycles. A command presented in the same cycle as the write is evaluated with the old value.
- R10: Reset clears `out_valid`, `out_alloc` and every configuration register, so no rule can set the flag until software has written the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cmd_valid | input | 1 | Command present |
| cmd_src | input | 2 | Source type code |
| cmd_addr | input | ADDR_W | Command address |
| cmd_isoc | input | 1 | Isochronous bit of a HyperTransport command |
| cmd_dma_id | input | ID_W | Issuing DMA engine |
| cmd_dma_kind | input | 2 | DMA access kind |
| cmd_pci_win | input | WIN_W | Matching PCI translation window |
| cmd_pci_hit | input | 1 | A PCI translation window matched |
| out_valid | output | 1 | Registered command present |
| out_src | output | 2 | Registered source code |
| out_addr | output | ADDR_W | Registered address |
| out_alloc | output | 1 | Allocate-on-miss flag |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that the source, kind, engine and window inputs are stable and meaningful whenever `cmd_valid` is high. `cmd_dma_id` must be below the engine count, and `cmd_pci_win` counts only when `cmd_pci_hit` is set. The stimulus changes inputs only on the falling edge, keeps engine and window indices within the defaults, and issues configuration writes either in idle cycles or in one cycle chosen to check that old values are used.

// File: rtl/alloc_hint_pkg.sv
package alloc_hint_pkg;

    typedef enum logic [1:0] {
        SRC_DMA   = 2'd0,
        SRC_HT    = 2'd1,
        SRC_PCI   = 2'd2,
        SRC_OTHER = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_DESC = 2'd1,
        KIND_HDR  = 2'd2,
        KIND_RSVD = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        REG_WIN_BASE = 3'd0,
        REG_WIN_MASK = 3'd1,
        REG_CTRL     = 3'd2,
        REG_DESC_EN  = 3'd3,
        REG_HDR_EN   = 3'd4,
        REG_PCI_ATTR = 3'd5
    } reg_e;

endpackage

// File: rtl/alloc_hint_cfg.sv
module alloc_hint_cfg
    import alloc_hint_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_DMA = 4,
    parameter int NUM_WIN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [2:0]         sel,
    input  logic [ADDR_W-1:0]  wdata,
    output logic [ADDR_W-1:0]  win_base,
    output logic [ADDR_W-1:0]  win_mask,
    output logic               win_en,
    output logic [NUM_DMA-1:0] desc_en,
    output logic [NUM_DMA-1:0] hdr_en,
    output logic [NUM_WIN-1:0] pci_attr
);

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  mask;
        logic               rev;
        logic [NUM_DMA-1:0] desc;
        logic [NUM_DMA-1:0] hdr;
        logic [NUM_WIN-1:0] attr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (reg_e'(sel))
                REG_WIN_BASE: cfg_d.base = wdata;
                REG_WIN_MASK: cfg_d.mask = wdata;
                REG_CTRL:     cfg_d.rev  = wdata[0];
                REG_DESC_EN:  cfg_d.desc = wdata[NUM_DMA-1:0];
                REG_HDR_EN:   cfg_d.hdr  = wdata[NUM_DMA-1:0];
                REG_PCI_ATTR: cfg_d.attr = wdata[NUM_WIN-1:0];
                default:      cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign win_base = cfg_q.base;
    assign win_mask = cfg_q.mask;
    assign win_en   = cfg_q.rev;
    assign desc_en  = cfg_q.desc;
    assign hdr_en   = cfg_q.hdr;
    assign pci_attr = cfg_q.attr;

    // R9: a control write lands on the next edge
    p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we && sel == REG_CTRL |=> win_en == $past(wdata[0]));

    // R9: without a write, the settings hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(desc_en) && $stable(hdr_en) && $stable(win_en));

endmodule

// File: rtl/alloc_hint_win.sv
module alloc_hint_win #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);

    logic [ADDR_W-1:0] diff;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign diff[b] = mask[b] & (addr[b] ^ base[b]);
    end

    assign hit = ~|diff;

endmodule

// File: rtl/alloc_hint_stage.sv
module alloc_hint_stage
    import alloc_hint_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_DMA = 4,
    parameter int NUM_WIN = 4,
    parameter int ID_W    = 2,
    parameter int WIN_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_src,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               cmd_isoc,
    input  logic [ID_W-1:0]    cmd_dma_id,
    input  logic [1:0]         cmd_dma_kind,
    input  logic [WIN_W-1:0]   cmd_pci_win,
    input  logic               cmd_pci_hit,
    input  logic               win_hit,
    input  logic               win_en,
    input  logic [NUM_DMA-1:0] desc_en,
    input  logic [NUM_DMA-1:0] hdr_en,
    input  logic [NUM_WIN-1:0] pci_attr,
    output logic               out_valid,
    output logic [1:0]         out_src,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_alloc
);

    typedef struct packed {
        logic              valid;
        logic [1:0]        src;
        logic [ADDR_W-1:0] addr;
        logic              alloc;
    } stage_t;

    stage_t st_d, st_q;
    logic   hint;

    always_comb begin
        hint = 1'b0;
        case (src_e'(cmd_src))
            SRC_DMA: begin
                case (kind_e'(cmd_dma_kind))
                    KIND_DESC: hint = desc_en[cmd_dma_id];
                    KIND_HDR:  hint = hdr_en[cmd_dma_id];
                    default:   hint = 1'b0;
                endcase
            end
            SRC_HT:  hint = cmd_isoc | (win_en & win_hit);
            SRC_PCI: hint = cmd_pci_hit & pci_attr[cmd_pci_win];
            default: hint = 1'b0;
        endcase

        st_d.valid = cmd_valid;
        st_d.src   = cmd_src;
        st_d.addr  = cmd_addr;
        st_d.alloc = cmd_valid & hint;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_src   = st_q.src;
    assign out_addr  = st_q.addr;
    assign out_alloc = st_q.alloc;

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> out_valid);
    p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !out_valid);
    p_addr_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> out_addr == $past(cmd_addr));
    p_payload_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_src == SRC_DMA && cmd_dma_kind == KIND_DATA |=> !out_alloc);
    p_isoc_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_src == SRC_HT && cmd_isoc |=> out_alloc);
    p_window_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_src == SRC_HT && !cmd_isoc && !win_en |=> !out_alloc);
    p_pci_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_src == SRC_PCI && !cmd_pci_hit |=> !out_alloc);
    p_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_src == SRC_OTHER |=> !out_alloc);
    p_idle_noalloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_alloc);

endmodule

// File: rtl/alloc_hint_gen.sv
module alloc_hint_gen
    import alloc_hint_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_DMA = 4,
    parameter int NUM_WIN = 4,
    parameter int ID_W    = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1,
    parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_src,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_isoc,
    input  logic [ID_W-1:0]   cmd_dma_id,
    input  logic [1:0]        cmd_dma_kind,
    input  logic [WIN_W-1:0]  cmd_pci_win,
    input  logic              cmd_pci_hit,
    output logic              out_valid,
    output logic [1:0]        out_src,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_alloc
);

    logic [ADDR_W-1:0]  win_base, win_mask;
    logic               win_en, win_hit;
    logic [NUM_DMA-1:0] desc_en, hdr_en;
    logic [NUM_WIN-1:0] pci_attr;

    alloc_hint_cfg #(
        .ADDR_W(ADDR_W), .NUM_DMA(NUM_DMA), .NUM_WIN(NUM_WIN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .win_base(win_base), .win_mask(win_mask), .win_en(win_en),
        .desc_en(desc_en), .hdr_en(hdr_en), .pci_attr(pci_attr)
    );

    alloc_hint_win #(.ADDR_W(ADDR_W)) u_win (
        .addr(cmd_addr), .base(win_base), .mask(win_mask), .hit(win_hit)
    );

    alloc_hint_stage #(
        .ADDR_W(ADDR_W), .NUM_DMA(NUM_DMA), .NUM_WIN(NUM_WIN),
        .ID_W(ID_W), .WIN_W(WIN_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_addr(cmd_addr),
        .cmd_isoc(cmd_isoc), .cmd_dma_id(cmd_dma_id), .cmd_dma_kind(cmd_dma_kind),
        .cmd_pci_win(cmd_pci_win), .cmd_pci_hit(cmd_pci_hit),
        .win_hit(win_hit), .win_en(win_en), .desc_en(desc_en), .hdr_en(hdr_en),
        .pci_attr(pci_attr),
        .out_valid(out_valid), .out_src(out_src), .out_addr(out_addr),
        .out_alloc(out_alloc)
    );

endmodule

// File: tb/alloc_hint_gen_bench.sv
module alloc_hint_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    // {src[42:41], addr[40:9], isoc[8], id[7:6], kind[5:4], win[3:2], hit[1], exp[0]}
    localparam logic [42:0] VECS [NV] = '{
        {2'd0, 32'h0000_1000, 1'b0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b1}, // R2 desc en
        {2'd0, 32'h0000_2000, 1'b0, 2'd1, 2'd1, 2'd0, 1'b0, 1'b0}, // R2 desc off
        {2'd0, 32'h0000_3000, 1'b0, 2'd1, 2'd2, 2'd0, 1'b0, 1'b1}, // R3 hdr en
        {2'd0, 32'h0000_4000, 1'b0, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0}, // R3 hdr off
        {2'd0, 32'h0000_5000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0}, // R3 payload
        {2'd0, 32'h0000_6000, 1'b0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0}, // R3 reserved
        {2'd1, 32'h0000_1000, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1}, // R4 isoc
        {2'd1, 32'h8123_4567, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1}, // R5 in window
        {2'd1, 32'h9000_0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0}, // R5 outside
        {2'd1, 32'h8000_0000, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1}, // R5 both
        {2'd2, 32'h0000_7000, 1'b0, 2'd0, 2'd0, 2'd1, 1'b1, 1'b1}, // R7 attr set
        {2'd2, 32'h0000_8000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0}, // R7 attr clear
        {2'd2, 32'h0000_9000, 1'b0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0}, // R7 no hit
        {2'd3, 32'h8000_0000, 1'b1, 2'd0, 2'd1, 2'd1, 1'b1, 1'b0}  // R8 other
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        cmd_valid;
    logic [1:0]  cmd_src;
    logic [31:0] cmd_addr;
    logic        cmd_isoc;
    logic [1:0]  cmd_dma_id;
    logic [1:0]  cmd_dma_kind;
    logic [1:0]  cmd_pci_win;
    logic        cmd_pci_hit;
    logic        out_valid;
    logic [1:0]  out_src;
    logic [31:0] out_addr;
    logic        out_alloc;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alloc_hint_gen u_alloc_hint_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
        .cmd_addr(cmd_addr), .cmd_isoc(cmd_isoc), .cmd_dma_id(cmd_dma_id),
        .cmd_dma_kind(cmd_dma_kind), .cmd_pci_win(cmd_pci_win),
        .cmd_pci_hit(cmd_pci_hit), .out_valid(out_valid), .out_src(out_src),
        .out_addr(out_addr), .out_alloc(out_alloc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_cmd(input logic [1:0] s, input logic [31:0] a, input logic iso,
                           input logic [1:0] id, input logic [1:0] k,
                           input logic [1:0] w, input logic h);
        cmd_valid = 1'b1; cmd_src = s; cmd_addr = a; cmd_isoc = iso;
        cmd_dma_id = id; cmd_dma_kind = k; cmd_pci_win = w; cmd_pci_hit = h;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] s, input logic [31:0] d);
        cmd_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        put_cmd(2'd0, 32'h0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0);
        cmd_valid = 1'b0;
        repeat (3) step();
        check("R10 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R10 alloc after reset", {31'd0, out_alloc}, 32'd0);
        rst_n = 1'b1;

        // R10: cleared configuration sets nothing
        put_cmd(2'd0, 32'h100, 1'b0, 2'd0, 2'd1, 2'd0, 1'b0); step();
        check("R10 desc cleared", {31'd0, out_alloc}, 32'd0);
        put_cmd(2'd1, 32'h1234_5678, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0); step();
        check("R10 window cleared", {31'd0, out_alloc}, 32'd0);
        put_cmd(2'd2, 32'h200, 1'b0, 2'd0, 2'd0, 2'd1, 1'b1); step();
        check("R10 pci attr cleared", {31'd0, out_alloc}, 32'd0);

        cfg_write(3'd0, 32'h8000_0000);
        cfg_write(3'd1, 32'hF000_0000);
        cfg_write(3'd2, 32'd1);
        cfg_write(3'd3, 32'b0101);
        cfg_write(3'd4, 32'b0011);
        cfg_write(3'd5, 32'b1010);

        for (int i = 0; i < NV; i++) begin
            put_cmd(VECS[i][42:41], VECS[i][40:9], VECS[i][8], VECS[i][7:6],
                    VECS[i][5:4], VECS[i][3:2], VECS[i][1]);
            step();
            check("R1 valid", {31'd0, out_valid}, 32'd1);
            check("R1 src", {30'd0, out_src}, {30'd0, VECS[i][42:41]});
            check("R1 addr", out_addr, VECS[i][40:9]);
            check($sformatf("R2-R8 vector %0d alloc", i), {31'd0, out_alloc},
                  {31'd0, VECS[i][0]});
        end

        // R6: window disabled
        cfg_write(3'd2, 32'd0);
        put_cmd(2'd1, 32'h8000_0040, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0); step();
        check("R6 window off", {31'd0, out_alloc}, 32'd0);
        put_cmd(2'd1, 32'h8000_0040, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0); step();
        check("R4 isoc with window off", {31'd0, out_alloc}, 32'd1);

        // R9: write and command in the same cycle
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 32'd0;
        put_cmd(2'd0, 32'h300, 1'b0, 2'd0, 2'd1, 2'd0, 1'b0);
        step();
        cfg_we = 1'b0;
        check("R9 same-cycle old value", {31'd0, out_alloc}, 32'd1);
        step();
        check("R9 next command new value", {31'd0, out_alloc}, 32'd0);

        // R8: idle
        cmd_valid = 1'b0; cmd_src = 2'd1; cmd_isoc = 1'b1; step();
        check("R8 idle valid", {31'd0, out_valid}, 32'd0);
        check("R8 idle alloc", {31'd0, out_alloc}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule